// File: doc/BRIEF.md
# Palettized framebuffer pixel unpacker

This block takes one frame of packed framebuffer bytes from a byte stream and turns it into a stream of 16-bit pixels, one line after another. Unless the load mode skips it, a frame opens with a colour table of 16-bit little-endian entries. Bits 14:12 of the first entry are a depth code. That code sets the pixel depth of the packed data that follows and the length of the table.

The block stores the table and checks that the whole frame fits in the buffer size it was given. It then unpacks each line. Indexed pixels go through the table. 16-bit pixels pass straight through, or are widened from a 12-bit colour. An optional window can start drawing at a chosen line or limit the number of lines drawn. A frame index, which alternates when double buffering is on, goes out with the frame-done pulse.

A frame starts with a one-cycle `start` while the block is idle. Its configuration inputs must stay stable until `busy` falls.

Top module: `pal_unpacker`

## Requirements
- R1: When `load_mode` is not 2, the frame opens with a header of 16-bit little-endian table entries (low byte first), stored at entry addresses 0, 1, 2 and so on. The header is 512 bytes for depth codes 3 to 7 and 32 bytes for codes 1 and 2. One `pal_done` pulse follows the last header byte.
- R2: The depth code is bits 14:12 of entry 0, which is bits 6:4 of the second header byte. Code 1 gives 2 bpp, code 2 gives 4 bpp, code 3 gives 8 bpp, and codes 4 to 7 give 16 bpp. Code 0 gives one `depth_err` pulse after the second byte. Nothing more is consumed and no pixel is produced.
- R3: With `load_mode` equal to 2, no header is read and the first byte is pixel data. The depth code and table from the last header are kept. If that code is 0, `depth_err` is pulsed and no byte is consumed.
- R4: Let `need` be the header length plus width·height·bpp/8. If `need` is greater than `buf_bytes`+2, one `sync_err` pulse is given. No pixel byte is consumed, and there is no pixel and no `frame_done`. When `need` equals `buf_bytes`+2, the frame is drawn.
- R5: At 2, 4 and 8 bpp, each byte holds 4, 2 or 1 table indices, the least significant field first. Each pixel is the table entry at that index.
- R6: At 16 bpp, each pixel is two bytes, low byte first. With `tft`=1 the value goes out unchanged. With `tft`=0, bits 11:0 are read as 4:4:4 red/green/blue and widened to 5:6:5 by repeating each field's top bits.
- R7: A line is width = `width_m1`+1 pixels and takes width·bpp/8 bytes; width·bpp is a multiple of 8. `px_eol` marks the last pixel of each line. `px_sof` marks only the first pixel sent in the frame.
- R8: With `sub_en`=1 and `sub_first`=1, the lines below `sub_lines` are consumed but not sent. Lines from `sub_lines` up to height-1 are sent.
- R9: With `sub_en`=1 and `sub_first`=0, only lines 0 to `sub_lines`-1 are consumed and sent. Bytes after them are left in the stream.
- R10: One `frame_done` pulse follows the last drawn line. `frame_idx`, valid with that pulse, gives the frame's index. The index starts at 0 and flips after each completed frame when `dual`=1. At most one of `frame_done`, `sync_err` and `depth_err` is high in any cycle.
- R11: While `px_valid` is high and `px_ready` is low, `px_valid`, `px_data` and `px_eol` stay unchanged.
- R12: After reset, `busy`, `px_valid` and `in_ready` are low. `in_ready` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a frame (sampled while idle) |
| load_mode | input | 2 | Value 2 means the frame has no header |
| tft | input | 1 | 16 bpp: 1 direct, 0 widened from 12-bit |
| dual | input | 1 | Alternate the frame index after each frame |
| width_m1 | input | 10 | Pixels per line minus one |
| height_m1 | input | 10 | Lines per frame minus one |
| buf_bytes | input | 24 | Declared buffer size in bytes |
| sub_en | input | 1 | Enable the line window |
| sub_first | input | 1 | Window value is the first line (1) or the line count (0) |
| sub_lines | input | 10 | Window line value |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| px_valid | output | 1 | Output pixel valid |
| px_data | output | 16 | Output pixel |
| px_sof | output | 1 | First pixel of frame |
| px_eol | output | 1 | Last pixel of line |
| px_ready | input | 1 | Output pixel taken |
| busy | output | 1 | Frame in progress |
| pal_done | output | 1 | Pulse: header loaded |
| frame_done | output | 1 | Pulse: frame finished |
| frame_idx | output | 1 | Index of the finished frame |
| sync_err | output | 1 | Pulse: frame larger than buffer |
| depth_err | output | 1 | Pulse: unsupported depth code |

## Verification
The assertions assume the configuration inputs do not change between `start` and the fall of `busy`. They also assume `start` arrives only while the block is idle and that each line fills whole bytes. The stimulus sets every field before raising `start` and leaves them alone until the outcome pulse. It only uses widths that are multiples of four pixels. Input bytes arrive with random gaps and the pixel sink stalls at random, so the hold rule is exercised. The byte stream always carries two spare bytes, which shows how many bytes the block actually consumed.

// File: rtl/pu_pkg.sv
package pu_pkg;

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_CHK, S_PIX, S_DONE} pu_state_e;

  // depth code -> bits per pixel (0 means unsupported)
  function automatic logic [4:0] code_bpp(input logic [2:0] code);
    case (code)
      3'd1:    return 5'd2;
      3'd2:    return 5'd4;
      3'd3:    return 5'd8;
      3'd0:    return 5'd0;
      default: return 5'd16;
    endcase
  endfunction

  // depth code -> header length in bytes
  function automatic logic [15:0] code_hdr_bytes(input logic [2:0] code);
    return (code >= 3'd3) ? 16'd512 : 16'd32;
  endfunction

  // pixels carried by one fetch (one byte, or one byte pair at 16 bpp)
  function automatic logic [2:0] pix_per_fetch(input logic [4:0] bpp);
    case (bpp)
      5'd2:    return 3'd4;
      5'd4:    return 3'd2;
      default: return 3'd1;
    endcase
  endfunction

  // bytes a frame occupies: header plus packed pixel data
  function automatic logic [31:0] frame_need(input logic [15:0] hdr, input logic [31:0] w,
                                             input logic [31:0] h, input logic [4:0] bpp);
    logic [31:0] bits;
    bits = w * h * {27'd0, bpp};
    return {16'd0, hdr} + (bits >> 3);
  endfunction

  // 4:4:4 colour widened to 5:6:5
  function automatic logic [15:0] rgb12_to_565(input logic [11:0] c);
    return {c[11:8], c[11], c[7:4], c[7:6], c[3:0], c[3]};
  endfunction

endpackage

// File: rtl/pu_palette.sv
module pu_palette #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int N = 1 << AW;

  logic [DW-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/pu_pixfmt.sv
module pu_pixfmt import pu_pkg::*; #(
  parameter int AW = 8
) (
  input  logic [15:0]   raw,
  input  logic [4:0]    bpp,
  input  logic          tft,
  output logic [AW-1:0] pal_addr,
  input  logic [15:0]   pal_data,
  output logic [15:0]   pix
);
  logic [7:0] idx;

  always_comb begin
    case (bpp)
      5'd2:    idx = {6'd0, raw[1:0]};
      5'd4:    idx = {4'd0, raw[3:0]};
      default: idx = raw[7:0];
    endcase
  end

  assign pal_addr = idx[AW-1:0];

  always_comb begin
    if (bpp == 5'd16) pix = tft ? raw : rgb12_to_565(raw[11:0]);
    else              pix = pal_data;
  end
endmodule

// File: rtl/pu_seq.sv
module pu_seq import pu_pkg::*; #(
  parameter int W_BITS  = 10,
  parameter int SZ_BITS = 24,
  parameter int PAL_AW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        load_mode,
  input  logic              dual,
  input  logic [W_BITS-1:0] width_m1,
  input  logic [W_BITS-1:0] height_m1,
  input  logic [SZ_BITS-1:0] buf_bytes,
  input  logic              sub_en,
  input  logic              sub_first,
  input  logic [W_BITS-1:0] sub_lines,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              pix_valid,
  output logic              pix_sof,
  output logic              pix_eol,
  input  logic              pix_ready,
  output logic [15:0]       raw_word,
  output logic [4:0]        bpp,
  output logic              pal_we,
  output logic [PAL_AW-1:0] pal_waddr,
  output logic [15:0]       pal_wdata,
  output logic              busy,
  output logic              pal_done,
  output logic              frame_done,
  output logic              frame_idx,
  output logic              sync_err,
  output logic              depth_err
);
  localparam int LN_BITS = W_BITS + 1;

  pu_state_e          st_q;
  logic [2:0]         code_q;
  logic [15:0]        hcnt_q, hdr_len_q;
  logic [7:0]         lo_q;
  logic [15:0]        bb_q;
  logic [2:0]         left_q;
  logic               half_q, sof_q, idx_cur_q;
  logic [W_BITS-1:0]  pxc_q;
  logic [LN_BITS-1:0] ln_q;

  // named events for the checks
  logic               fetch, advance, visible, line_last;
  logic [W_BITS-1:0]  first_line;
  logic [LN_BITS-1:0] line_end;
  logic [15:0]        hdr_off;
  logic [31:0]        need, room;

  assign bpp        = code_bpp(code_q);
  assign first_line = (sub_en && sub_first) ? sub_lines : '0;
  assign line_end   = (sub_en && !sub_first) ? {1'b0, sub_lines}
                                             : {1'b0, height_m1} + LN_BITS'(1);
  assign hdr_off    = (load_mode == 2'd2) ? 16'd0 : code_hdr_bytes(code_q);
  assign need       = frame_need(hdr_off, {{(32-W_BITS){1'b0}}, width_m1} + 32'd1,
                                 {{(32-W_BITS){1'b0}}, height_m1} + 32'd1, bpp);
  assign room       = {{(32-SZ_BITS){1'b0}}, buf_bytes} + 32'd2;

  assign visible    = ln_q >= {1'b0, first_line};
  assign fetch      = (st_q == S_PIX) && (left_q == 3'd0);
  assign pix_valid  = (st_q == S_PIX) && (left_q != 3'd0) && visible;
  assign advance    = (st_q == S_PIX) && (left_q != 3'd0) && (!visible || pix_ready);
  assign line_last  = (pxc_q == width_m1);
  assign pix_eol    = pix_valid && line_last;
  assign pix_sof    = pix_valid && sof_q;
  assign in_ready   = (st_q == S_HDR) || fetch;
  assign raw_word   = bb_q;
  assign busy       = (st_q != S_IDLE);

  assign pal_we     = (st_q == S_HDR) && in_valid && hcnt_q[0];
  assign pal_waddr  = hcnt_q[PAL_AW:1];
  assign pal_wdata  = {in_data, lo_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;   code_q <= '0;   hcnt_q <= '0;  hdr_len_q <= 16'd32;
      lo_q <= '0;       bb_q <= '0;     left_q <= '0;  half_q <= 1'b0;
      sof_q <= 1'b0;    idx_cur_q <= 1'b0; pxc_q <= '0; ln_q <= '0;
      pal_done <= 1'b0; frame_done <= 1'b0; frame_idx <= 1'b0;
      sync_err <= 1'b0; depth_err <= 1'b0;
    end else begin
      pal_done <= 1'b0; frame_done <= 1'b0; sync_err <= 1'b0; depth_err <= 1'b0;
      case (st_q)
        S_IDLE: if (start) begin
          hcnt_q <= '0; ln_q <= '0; pxc_q <= '0; left_q <= '0;
          half_q <= 1'b0; sof_q <= 1'b1;
          st_q <= (load_mode == 2'd2) ? S_CHK : S_HDR;
        end
        S_HDR: if (in_valid) begin
          hcnt_q <= hcnt_q + 16'd1;
          if (!hcnt_q[0]) lo_q <= in_data;
          if (hcnt_q == 16'd1) begin
            code_q    <= in_data[6:4];
            hdr_len_q <= code_hdr_bytes(in_data[6:4]);
            if (in_data[6:4] == 3'd0) begin
              depth_err <= 1'b1;
              st_q      <= S_IDLE;
            end
          end else if (hcnt_q >= 16'd2 && hcnt_q == hdr_len_q - 16'd1) begin
            pal_done <= 1'b1;
            st_q     <= S_CHK;
          end
        end
        S_CHK: begin
          if (code_q == 3'd0) begin
            depth_err <= 1'b1;
            st_q      <= S_IDLE;
          end else if (need > room) begin
            sync_err <= 1'b1;
            st_q     <= S_IDLE;
          end else if ({1'b0, first_line} >= line_end) begin
            st_q <= S_DONE;
          end else begin
            st_q <= S_PIX;
          end
        end
        S_PIX: begin
          if (fetch && in_valid) begin
            if (bpp == 5'd16) begin
              if (!half_q) begin
                bb_q[7:0] <= in_data;
                half_q    <= 1'b1;
              end else begin
                bb_q[15:8] <= in_data;
                half_q     <= 1'b0;
                left_q     <= 3'd1;
              end
            end else begin
              bb_q   <= {8'd0, in_data};
              left_q <= pix_per_fetch(bpp);
            end
          end
          if (advance) begin
            bb_q   <= bb_q >> bpp;
            left_q <= left_q - 3'd1;
            if (pix_valid) sof_q <= 1'b0;
            if (line_last) begin
              pxc_q  <= '0;
              left_q <= 3'd0;
              ln_q   <= ln_q + LN_BITS'(1);
              if (ln_q + LN_BITS'(1) == line_end) st_q <= S_DONE;
            end else begin
              pxc_q <= pxc_q + W_BITS'(1);
            end
          end
        end
        S_DONE: begin
          frame_done <= 1'b1;
          frame_idx  <= idx_cur_q;
          idx_cur_q  <= idx_cur_q ^ dual;
          st_q       <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  AST_PIX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !pix_ready |=> pix_valid && $stable(raw_word) && $stable(pix_eol)); // R11
  AST_PALDONE_AFTER_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    pal_done |-> $past(pal_we)); // R1
  AST_DEPTH_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    depth_err |-> !busy && !pix_valid); // R2
  AST_SYNC_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |=> !pix_valid && !frame_done); // R4
  AST_SOF_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_ready |=> !pix_sof); // R7
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frame_done, sync_err, depth_err})); // R10
endmodule

// File: rtl/pal_unpacker.sv
module pal_unpacker import pu_pkg::*; #(
  parameter int W_BITS  = 10,
  parameter int SZ_BITS = 24,
  parameter int PAL_AW  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         load_mode,
  input  logic               tft,
  input  logic               dual,
  input  logic [W_BITS-1:0]  width_m1,
  input  logic [W_BITS-1:0]  height_m1,
  input  logic [SZ_BITS-1:0] buf_bytes,
  input  logic               sub_en,
  input  logic               sub_first,
  input  logic [W_BITS-1:0]  sub_lines,
  input  logic               in_valid,
  input  logic [7:0]         in_data,
  output logic               in_ready,
  output logic               px_valid,
  output logic [15:0]        px_data,
  output logic               px_sof,
  output logic               px_eol,
  input  logic               px_ready,
  output logic               busy,
  output logic               pal_done,
  output logic               frame_done,
  output logic               frame_idx,
  output logic               sync_err,
  output logic               depth_err
);
  logic [15:0]       raw_word, pal_rdata, pal_wdata;
  logic [4:0]        bpp;
  logic              pal_we;
  logic [PAL_AW-1:0] pal_waddr, pal_raddr;

  pu_seq #(.W_BITS(W_BITS), .SZ_BITS(SZ_BITS), .PAL_AW(PAL_AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .load_mode(load_mode), .dual(dual),
    .width_m1(width_m1), .height_m1(height_m1), .buf_bytes(buf_bytes),
    .sub_en(sub_en), .sub_first(sub_first), .sub_lines(sub_lines),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .pix_valid(px_valid), .pix_sof(px_sof), .pix_eol(px_eol), .pix_ready(px_ready),
    .raw_word(raw_word), .bpp(bpp),
    .pal_we(pal_we), .pal_waddr(pal_waddr), .pal_wdata(pal_wdata),
    .busy(busy), .pal_done(pal_done), .frame_done(frame_done), .frame_idx(frame_idx),
    .sync_err(sync_err), .depth_err(depth_err)
  );

  pu_palette #(.AW(PAL_AW), .DW(16)) u_pal (
    .clk(clk), .wr_en(pal_we), .wr_addr(pal_waddr), .wr_data(pal_wdata),
    .rd_addr(pal_raddr), .rd_data(pal_rdata)
  );

  pu_pixfmt #(.AW(PAL_AW)) u_fmt (
    .raw(raw_word), .bpp(bpp), .tft(tft),
    .pal_addr(pal_raddr), .pal_data(pal_rdata), .pix(px_data)
  );

  AST_READY_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> busy); // R12
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid && !px_ready && !pal_we |=> $stable(px_data)); // R11
endmodule

// File: tb/pal_unpacker_bench.sv
module pal_unpacker_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, tft = 1'b0, dual = 1'b0, sub_en = 1'b0, sub_first = 1'b0;
  logic [1:0]  load_mode = 2'd0;
  logic [9:0]  width_m1 = '0, height_m1 = '0, sub_lines = '0;
  logic [23:0] buf_bytes = '0;
  logic        in_valid = 1'b0, px_ready = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, px_valid, px_sof, px_eol, busy;
  logic        pal_done, frame_done, frame_idx, sync_err, depth_err;
  logic [15:0] px_data;

  always #2.5 clk = ~clk;

  pal_unpacker u_pal_unpacker (
    .clk(clk), .rst_n(rst_n), .start(start), .load_mode(load_mode), .tft(tft), .dual(dual),
    .width_m1(width_m1), .height_m1(height_m1), .buf_bytes(buf_bytes),
    .sub_en(sub_en), .sub_first(sub_first), .sub_lines(sub_lines),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .px_valid(px_valid), .px_data(px_data), .px_sof(px_sof), .px_eol(px_eol),
    .px_ready(px_ready), .busy(busy), .pal_done(pal_done), .frame_done(frame_done),
    .frame_idx(frame_idx), .sync_err(sync_err), .depth_err(depth_err)
  );

  int errs = 0, checks = 0;
  logic [7:0]  inq[$];
  logic [17:0] expq[$];
  logic [15:0] mpal [256];
  int mcode = 0, idx_m = 0;
  int consumed, n_pal, n_done, n_sync, n_derr, got_idx;
  bit start_req = 0, hold_pend = 0, hold_eol = 0;
  logic [15:0] hold_data = '0;
  string px_req = "R5";

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int depth_of(input int code);
    if (code == 0) return 0;
    if (code == 1) return 2;
    if (code == 2) return 4;
    if (code == 3) return 8;
    return 16;
  endfunction

  function automatic logic [15:0] widen(input logic [15:0] v);
    int r, g, b;
    r = (v >> 8) & 15; g = (v >> 4) & 15; b = v & 15;
    return 16'(((r * 2 + r / 8) << 11) | ((g * 4 + g / 4) << 5) | (b * 2 + b / 8));
  endfunction

  task automatic step();
    logic [17:0] e;
    @(negedge clk);
    start = start_req; start_req = 0;
    if (inq.size() > 0 && $urandom_range(3) != 0) begin
      in_valid = 1'b1; in_data = inq[0];
    end else begin
      in_valid = 1'b0; in_data = 8'h00;
    end
    px_ready = ($urandom_range(2) != 0);
    #1;
    if (hold_pend)
      check(px_valid && px_data == hold_data && px_eol == hold_eol, "R11 hold", px_data, hold_data);
    hold_pend = px_valid && !px_ready; hold_data = px_data; hold_eol = px_eol;
    if (in_valid && in_ready) begin
      void'(inq.pop_front());
      consumed++;
    end
    if (px_valid && px_ready) begin
      if (expq.size() == 0) check(1'b0, "R7 extra pixel", px_data, 0);
      else begin
        e = expq.pop_front();
        check({px_sof, px_eol, px_data} == e, px_req, {px_sof, px_eol, px_data}, e);
      end
    end
    if (pal_done) n_pal++;
    if (sync_err) n_sync++;
    if (depth_err) n_derr++;
    if (frame_done) begin n_done++; got_idx = frame_idx; end
  endtask

  task automatic run_frame(input string req, input int mode, input int code, input bit tft_i,
                           input bit dual_i, input int w, input int h, input int bufb,
                           input bit sen, input bit sfirst, input int sval);
    int hdr, bpp, kind, lines_c, firstl, lb, exp_cons, total, exp_idx;
    bit first_px;
    inq.delete(); expq.delete();
    hdr = 0;
    if (mode != 2) begin
      hdr = (code >= 3) ? 512 : 32;
      for (int e = 0; e < hdr / 2; e++) begin
        logic [15:0] v;
        v = 16'($urandom);
        if (e == 0) v[14:12] = 3'(code);
        if (code != 0 || e == 0) mpal[e] = v;
        inq.push_back(v[7:0]); inq.push_back(v[15:8]);
      end
      mcode = code;
    end
    bpp = depth_of(mcode);
    if (mcode == 0) kind = 2;
    else if (hdr + w * h * bpp / 8 > bufb + 2) kind = 1;
    else kind = 0;
    lines_c = (sen && !sfirst) ? sval : h;
    firstl  = (sen && sfirst) ? sval : 0;
    if (firstl >= lines_c) lines_c = 0;
    lb = w * bpp / 8;
    first_px = 1;
    for (int l = 0; l < lines_c; l++) begin
      logic [7:0] lbytes[$];
      for (int b = 0; b < lb; b++) begin
        logic [7:0] r;
        r = 8'($urandom);
        lbytes.push_back(r); inq.push_back(r);
      end
      if (kind == 0 && l >= firstl) begin
        for (int p = 0; p < w; p++) begin
          logic [15:0] pix;
          if (bpp == 16) begin
            pix = {lbytes[2*p+1], lbytes[2*p]};
            if (!tft_i) pix = widen(pix);
          end else begin
            pix = mpal[(lbytes[p * bpp / 8] >> ((p * bpp) % 8)) & ((1 << bpp) - 1)];
          end
          expq.push_back({first_px, p == w - 1, pix});
          first_px = 0;
        end
      end
    end
    inq.push_back(8'hA5); inq.push_back(8'h5A);
    total = inq.size();
    if (kind == 2) exp_cons = (mode != 2) ? 2 : 0;
    else if (kind == 1) exp_cons = hdr;
    else exp_cons = hdr + lines_c * lb;
    exp_idx = idx_m;
    if (kind == 0 && dual_i) idx_m ^= 1;

    load_mode = 2'(mode); tft = tft_i; dual = dual_i;
    width_m1 = 10'(w - 1); height_m1 = 10'(h - 1); buf_bytes = 24'(bufb);
    sub_en = sen; sub_first = sfirst; sub_lines = 10'(sval);
    consumed = 0; n_pal = 0; n_done = 0; n_sync = 0; n_derr = 0; got_idx = -1;
    px_req = req;
    start_req = 1;
    for (int k = 0; k < 60000 && (n_done + n_sync + n_derr) == 0; k++) step();
    repeat (8) step();

    check(consumed == exp_cons, {req, " bytes consumed"}, consumed, exp_cons);
    check(inq.size() == total - exp_cons, {req, " bytes left"}, inq.size(), total - exp_cons);
    check(expq.size() == 0, {req, " pixels missing"}, expq.size(), 0);
    check(n_pal == ((mode != 2 && kind != 2) ? 1 : 0), "R1 pal_done count", n_pal,
          (mode != 2 && kind != 2) ? 1 : 0);
    check(n_sync == (kind == 1 ? 1 : 0), "R4 sync_err count", n_sync, kind == 1);
    check(n_derr == (kind == 2 ? 1 : 0), "R2 depth_err count", n_derr, kind == 2);
    check(n_done == (kind == 0 ? 1 : 0), "R10 frame_done count", n_done, kind == 0);
    if (kind == 0) check(got_idx == exp_idx, "R10 frame_idx", got_idx, exp_idx);
    check(!busy && !px_valid, {req, " idle after frame"}, busy, 0);
  endtask

  initial begin
    #750000;
    errs++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!busy && !px_valid && !in_ready, "R12 reset state", {busy, px_valid, in_ready}, 0);
    rst_n = 1'b1;
    repeat (2) step();
    check(!in_ready && !busy, "R12 idle after reset", {busy, in_ready}, 0);

    run_frame("R5 8bpp",            1, 3, 0, 0, 8, 4, 4096, 0, 0, 0);
    run_frame("R5 2bpp",            0, 1, 0, 0, 8, 3, 4096, 0, 0, 0);
    run_frame("R5 4bpp",            0, 2, 0, 0, 8, 3, 4096, 0, 0, 0);
    run_frame("R6 16bpp direct",    0, 5, 1, 1, 4, 3, 4096, 0, 0, 0);
    run_frame("R6 16bpp widened",   0, 4, 0, 1, 4, 2, 4096, 0, 0, 0);
    run_frame("R3 no header",       2, 0, 0, 0, 4, 2, 4096, 0, 0, 0);
    run_frame("R8 first line",      1, 3, 0, 0, 8, 6, 4096, 1, 1, 2);
    run_frame("R9 line count",      1, 3, 0, 0, 8, 6, 4096, 1, 0, 3);
    run_frame("R7 R4 size at edge", 0, 3, 0, 0, 8, 4, 542,  0, 0, 0);
    run_frame("R4 size over",       0, 3, 0, 0, 8, 4, 541,  0, 0, 0);
    run_frame("R2 code zero",       0, 0, 0, 0, 8, 2, 4096, 0, 0, 0);
    run_frame("R3 stored code zero",2, 0, 0, 0, 8, 2, 4096, 0, 0, 0);
    run_frame("R5 4bpp recover",    0, 2, 0, 1, 4, 2, 4096, 0, 0, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule